// File: doc/BRIEF.md
# Feedback Deviation Counter

This block keeps a signed tally of how far a feedback pulse source, usually an encoder, lags or leads the pulse train a motion generator emits. Each command pulse raises the tally by one and each qualifying feedback event lowers it by one. An initialize strobe zeroes the tally and latches two settings. The first is which transitions of the feedback clock count. The second is an integer divisor that thins the feedback events so both sources run at the same rate.

Two window comparators watch the magnitude of the tally. The "near" comparator flags that the axis has settled: the magnitude is at or below its limit. The "far" comparator flags a following error: the magnitude is above its limit. Each comparator has its own enable. The two enabled flags drive a two-bit cause word, and their OR drives a single interrupt line. When the interrupt is shared, software reads the cause word to learn the reason.

Top module: `pulse_dev_counter`

## Requirements
- R1: While reset is asserted and before the first active clock edge after reset, `count_o` is 0, `cause_o` is 2'b00 and `irq_o` is 0.
- R2: With only `out_pulse_i` high in a cycle, `count_o` increases by one at that clock edge.
- R3: A feedback tick on its own lowers `count_o` by one at the clock edge where it is detected. A tick is a qualifying transition of `fb_clk_i`, measured against its level at the previous edge and then passed by the divider.
- R4: If an output pulse and a feedback tick fall in the same cycle, `count_o` keeps its value.
- R5: `count_o` is 16-bit two's complement and saturates at +32767 and -32768. It never wraps.
- R6: The feedback mode code is latched by `init_i`. Code 0 counts rising edges, 1 counts falling edges, 2 counts both edges and 3 counts none. After reset the mode is 0.
- R7: The divisor code d, latched by `init_i`, produces one tick per d+1 qualifying transitions. Code 0 passes every transition, and the divider phase restarts at init. After reset the code is 0.
- R8: A cycle with `init_i` high sets `count_o` to 0 at that edge, and any pulse or feedback edge in that cycle has no effect.
- R9: `cause_o[0]` is registered one edge after the count it judges. It is 1 when `near_en_i` is 1 and |count| <= `near_lim_i`.
- R10: `cause_o[1]` is registered the same way. It is 1 when `far_en_i` is 1 and |count| > `far_lim_i`.
- R11: `irq_o` is 1 exactly when either bit of `cause_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialize: clear count and divider phase, latch mode and divisor |
| fb_mode_i | input | 2 | Feedback transition select (0 rise, 1 fall, 2 both, 3 none) |
| fb_div_i | input | 8 | Divisor code d, divide by d+1 |
| out_pulse_i | input | 1 | One-cycle strobe per generated output pulse |
| fb_clk_i | input | 1 | Feedback clock level, already synchronous |
| near_lim_i | input | 16 | Settled-window limit |
| near_en_i | input | 1 | Enable for settled flag |
| far_lim_i | input | 16 | Following-error limit |
| far_en_i | input | 1 | Enable for following-error flag |
| count_o | output | 16 | Signed deviation |
| cause_o | output | 2 | Bit 0 settled, bit 1 following error |
| irq_o | output | 1 | Merged interrupt |

## Verification
Directed patterns use isolated pulses, isolated feedback edges and coincident pairs to separate the increment, decrement and hold paths. Each of the four transition modes is run, and a divide-by-three run shows the point where the divider releases its first tick. Long runs in one direction only push the tally into both rails, which shows whether it saturates or wraps. Random runs mix modes, divisors up to 256, re-inits and changing limits and enables. This brings the magnitude close to both limits, so the at-or-below and strictly-above edges of the two comparators and the interrupt merge are both exercised.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    FB_RISE = 2'd0,
    FB_FALL = 2'd1,
    FB_BOTH = 2'd2,
    FB_NONE = 2'd3
  } fb_mode_e;
endpackage

// File: rtl/pdc_prescaler.sv
module pdc_prescaler
  import pdc_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic            fb_clk_i,
  input  fb_mode_e        mode_i,
  input  logic [DIVW-1:0] div_i,
  output logic            tick_o
);
  logic            fb_q;
  fb_mode_e        mode_q;
  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] pre_q;
  logic            edge_hit;
  logic            wrap;

  always_comb begin
    unique case (mode_q)
      FB_RISE: edge_hit = fb_clk_i & ~fb_q;
      FB_FALL: edge_hit = ~fb_clk_i & fb_q;
      FB_BOTH: edge_hit = fb_clk_i ^ fb_q;
      default: edge_hit = 1'b0;
    endcase
  end

  assign wrap   = (pre_q == div_q);
  assign tick_o = edge_hit & wrap & ~init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_q   <= 1'b0;
      mode_q <= FB_RISE;
      div_q  <= '0;
      pre_q  <= '0;
    end else begin
      fb_q <= fb_clk_i;
      if (init_i) begin
        mode_q <= mode_i;
        div_q  <= div_i;
        pre_q  <= '0;
      end else if (edge_hit) begin
        pre_q <= wrap ? '0 : pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdc_accum.sv
module pdc_accum #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic                up_i,
  input  logic                dn_i,
  output logic signed [W-1:0] count_o
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (init_i) begin
      count_o <= '0;
    end else if (up_i && !dn_i && count_o != MAXV) begin
      count_o <= count_o + 1'b1;
    end else if (dn_i && !up_i && count_o != MINV) begin
      count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/pdc_compare.sv
module pdc_compare #(
  parameter int W      = 16,
  parameter bit EXCESS = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] count_i,
  input  logic        [W-1:0] limit_i,
  input  logic                en_i,
  output logic                hit_o
);
  logic signed [W:0] ext;
  logic        [W:0] mag;
  logic              match;

  assign ext = {count_i[W-1], count_i};
  assign mag = ext[W] ? $unsigned(-ext) : $unsigned(ext);

  generate
    if (EXCESS) begin : g_above
      assign match = mag > {1'b0, limit_i};
    end else begin : g_within
      assign match = mag <= {1'b0, limit_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else         hit_o <= en_i & match;
  end
endmodule

// File: rtl/pulse_dev_counter.sv
module pulse_dev_counter
  import pdc_pkg::*;
#(
  parameter int W    = 16,
  parameter int DIVW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic [1:0]          fb_mode_i,
  input  logic [DIVW-1:0]     fb_div_i,
  input  logic                out_pulse_i,
  input  logic                fb_clk_i,
  input  logic [W-1:0]        near_lim_i,
  input  logic                near_en_i,
  input  logic [W-1:0]        far_lim_i,
  input  logic                far_en_i,
  output logic signed [W-1:0] count_o,
  output logic [1:0]          cause_o,
  output logic                irq_o
);
  localparam int NCMP = 2;

  logic         fb_tick;
  logic [W-1:0] lim [NCMP];
  logic         en  [NCMP];

  assign lim[0] = near_lim_i;
  assign lim[1] = far_lim_i;
  assign en[0]  = near_en_i;
  assign en[1]  = far_en_i;

  pdc_prescaler #(.DIVW(DIVW)) i_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .fb_clk_i(fb_clk_i),
    .mode_i  (fb_mode_e'(fb_mode_i)),
    .div_i   (fb_div_i),
    .tick_o  (fb_tick)
  );

  pdc_accum #(.W(W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .up_i   (out_pulse_i),
    .dn_i   (fb_tick),
    .count_o(count_o)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    pdc_compare #(.W(W), .EXCESS(g == 1)) i_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .count_i(count_o),
      .limit_i(lim[g]),
      .en_i   (en[g]),
      .hit_o  (cause_o[g])
    );
  end

  assign irq_o = |cause_o;
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                init_i,
  input logic                out_pulse_i,
  input logic                fb_tick_i,
  input logic                far_en_i,
  input logic signed [W-1:0] count_o,
  input logic [1:0]          cause_o
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_pulse_i && !fb_tick_i && !init_i && count_o != MAXV)
      |=> (W'(count_o - $past(count_o)) == W'(1)));

  // R3
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_tick_i && !out_pulse_i && !init_i && count_o != MINV)
      |=> (W'($past(count_o) - count_o) == W'(1)));

  // R4
  hold_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_pulse_i && fb_tick_i && !init_i) |=> $stable(count_o));

  // R5
  no_wrap_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == MAXV && !init_i) |=> count_o != MINV);

  // R5
  no_wrap_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == MINV && !init_i) |=> count_o != MAXV);

  // R8
  init_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> count_o == '0);

  // R10
  far_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_o[1] |-> $past(far_en_i));
endmodule

bind pulse_dev_counter pdc_checker #(.W(W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_i     (init_i),
  .out_pulse_i(out_pulse_i),
  .fb_tick_i  (fb_tick),
  .far_en_i   (far_en_i),
  .count_o    (count_o),
  .cause_o    (cause_o)
);

// File: tb/test_pulse_dev_counter.sv
module test_pulse_dev_counter;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               init_i = 1'b0;
  logic [1:0]         fb_mode_i = '0;
  logic [7:0]         fb_div_i = '0;
  logic               out_pulse_i = 1'b0;
  logic               fb_clk_i = 1'b0;
  logic [15:0]        near_lim_i = '0;
  logic               near_en_i = 1'b0;
  logic [15:0]        far_lim_i = '0;
  logic               far_en_i = 1'b0;
  logic signed [15:0] count_o;
  logic [1:0]         cause_o;
  logic               irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_cnt = 0, m_pre = 0, m_div = 0, m_mode = 0;
  bit m_fbprev = 0;
  bit [1:0] m_cause = 2'b00;

  always #10 clk_i = ~clk_i;

  pulse_dev_counter i_pulse_dev_counter (.*);

  function automatic bit [1:0] cause_of(int c);
    int a = (c < 0) ? -c : c;
    bit [1:0] r;
    r[0] = near_en_i && (a <= int'(near_lim_i));
    r[1] = far_en_i && (a > int'(far_lim_i));
    return r;
  endfunction

  function automatic bit edge_of(int mode, bit prev, bit cur);
    case (mode)
      0: return cur & ~prev;
      1: return ~cur & prev;
      2: return cur ^ prev;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(bit ini, bit op, bit fb, int mode = 0, int div = 0);
    bit e, t;
    init_i = ini; out_pulse_i = op; fb_clk_i = fb;
    fb_mode_i = mode[1:0]; fb_div_i = div[7:0];
    m_cause = cause_of(m_cnt);
    e = edge_of(m_mode, m_fbprev, fb);
    if (ini) begin
      m_cnt = 0; m_pre = 0; m_mode = mode; m_div = div;
    end else begin
      t = e && (m_pre == m_div);
      if (e) m_pre = t ? 0 : m_pre + 1;
      if (op && !t && m_cnt < 32767) m_cnt++;
      else if (t && !op && m_cnt > -32768) m_cnt--;
    end
    m_fbprev = fb;
    @(posedge clk_i);
    @(negedge clk_i);
    init_i = 1'b0;
  endtask

  task automatic chk_cnt(string r);
    checks++;
    if (int'(count_o) != m_cnt) begin
      fails++;
      $display("FAIL %s: count_o=%0d expected %0d", r, count_o, m_cnt);
    end
  endtask

  task automatic chk_cause(string r);
    checks++;
    if (cause_o !== m_cause || irq_o !== (|m_cause)) begin
      fails++;
      $display("FAIL %s: cause_o=%b irq_o=%b expected %b/%b", r, cause_o, irq_o,
               m_cause, |m_cause);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    checks++;
    if (count_o !== 16'sd0 || cause_o !== 2'b00 || irq_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: count=%0d cause=%b irq=%b expected 0/00/0", count_o, cause_o, irq_o);
    end
    rst_ni = 1'b1;
    checks++;
    if (count_o !== 16'sd0 || cause_o !== 2'b00 || irq_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: count=%0d cause=%b irq=%b expected 0/00/0", count_o, cause_o, irq_o);
    end

    step(0, 1, 0); chk_cnt("R2");              // +1
    step(0, 0, 1); chk_cnt("R3");              // rising edge -1
    step(0, 0, 0);
    step(0, 1, 1); chk_cnt("R4");              // coincident: hold
    // R6 falling mode
    step(1, 0, 1, 1, 0); chk_cnt("R8");
    step(0, 0, 0); chk_cnt("R6");              // falling -> -1
    step(0, 0, 1); chk_cnt("R6");              // rising ignored
    // R6 none mode
    step(1, 0, 0, 3, 0);
    step(0, 0, 1); step(0, 0, 0); chk_cnt("R6");
    // R7 divide by three
    step(1, 0, 0, 0, 2);
    step(0, 0, 1); step(0, 0, 0);
    step(0, 0, 1); step(0, 0, 0); chk_cnt("R7");
    step(0, 0, 1); chk_cnt("R7");
    // R8 init ignores pulse and edge
    step(0, 1, 0); step(0, 1, 0);
    step(1, 1, 1, 0, 0); chk_cnt("R8");
    // R9 R10 R11 window flags
    near_lim_i = 16'd2; near_en_i = 1'b1; far_lim_i = 16'd5; far_en_i = 1'b1;
    step(0, 0, 1); step(0, 0, 1); chk_cause("R9");
    for (int i = 0; i < 6; i++) step(0, 1, 1);
    step(0, 0, 1); chk_cause("R10"); chk_cnt("R10");
    step(0, 0, 1); chk_cause("R11");
    near_en_i = 1'b0; far_en_i = 1'b0;
    step(0, 0, 1); step(0, 0, 1); chk_cause("R11");

    // R5 saturation both ways
    step(1, 0, 0, 2, 0);
    for (int i = 0; i < 32800; i++) step(0, 1, 0);
    chk_cnt("R5");
    for (int i = 0; i < 65600; i++) step(0, 0, (i % 2) == 0);
    chk_cnt("R5");

    // random mix
    step(1, 0, m_fbprev, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      bit ini = ($urandom % 150) == 0;
      int md = $urandom % 4;
      int dv = (($urandom % 20) == 0) ? 255 : int'($urandom % 4);
      if (($urandom % 40) == 0) begin
        near_lim_i = 16'($urandom % 12); far_lim_i = 16'($urandom % 16);
        near_en_i = 1'($urandom); far_en_i = 1'($urandom);
      end
      step(ini, ($urandom % 3) == 0, 1'($urandom), md, dv);
      chk_cnt(ini ? "R8" : "R7");
      chk_cause(m_cause[1] ? "R10" : "R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule